// File: doc/BRIEF.md
# Debug Probe Control Register

This block is a 32-bit control and status word that an external debug probe reads and writes through a scan-side register port. It tracks whether the processor has a load or store to the debug memory segment waiting for the probe. It holds an enable that tells the probe to service those accesses, and it carries a break request that asks the core to take a debug interrupt. It also turns one select bit into the address of the debug exception vector.

The fields follow different write rules. The pending flag can only be cleared by the probe. The break request can only be set by the probe. The enable and the vector select are plain storage. Two side channels also change state: a fast-data completion pulse clears the pending flag, and a core acknowledge clears the break request. Ten bit positions belong to logic outside this block. They are fed in as status and show up in the read word unchanged.

Top module: `dbg_probe_ctl`

## Requirements
- R1: After reset the pending flag, service enable, vector select, break request and done pulse are all 0.
- R2: Bit positions 28-24, 17, 13, 11-4 and 2-0 read as 0, and writing 1 to them changes no output.
- R3: The pending flag is bit 18. A probe write with bit 18 at 0 clears the flag at the next edge. A write with bit 18 at 1 leaves it unchanged.
- R4: A fast-data completion pulse clears the pending flag at the next edge.
- R5: A processor access-request pulse sets the pending flag at the next edge. This takes priority over a write-0 clear or a fast-data clear in the same cycle.
- R6: Bit 15 is the service enable. A write loads it from bit 15, and the value is driven on `svc_en_o`.
- R7: Bit 14 is the vector select. A write loads it from bit 14. `dbg_vec_o` is 0xFF200200 when the select is 1 and 0xBFC00480 when it is 0.
- R8: Bit 12 is the break request. A write with bit 12 at 1 sets it, and a write with bit 12 at 0 leaves it unchanged.
- R9: A core acknowledge pulse clears the break request at the next edge, unless a write with bit 12 at 1 arrives in the same cycle, in which case the request is set.
- R10: Status input bits 2:0 appear at read bits 31:29, bits 7:3 at 23:19, bit 8 at 16 and bit 9 at 3.
- R11: `rd_data_o` shows the current register state and status inputs in the same cycle, with no clock delay.
- R12: `acc_done_o` is 1 for exactly the cycle that follows an edge where the pending flag went from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asynchronous assert, synchronous release |
| wr_en_i | input | 1 | Probe write strobe |
| wr_data_i | input | 32 | Probe write data |
| rd_data_o | output | 32 | Current register read word |
| acc_req_i | input | 1 | Processor pulse: a debug-segment access is waiting |
| fast_done_i | input | 1 | Pulse: a fast-data transfer finished successfully |
| brk_ack_i | input | 1 | Core pulse: debug mode has been entered |
| ext_stat_i | input | 10 | Externally defined status bits for the read word |
| pend_o | output | 1 | Pending-access flag |
| svc_en_o | output | 1 | Probe services debug-segment accesses |
| brk_req_o | output | 1 | Debug interrupt request to the core |
| dbg_vec_o | output | 32 | Selected debug exception vector |
| acc_done_o | output | 1 | One-cycle pulse when a pending access completes |

## Verification
The bench builds the block with its default vector parameters, 0xFF200200 and 0xBFC00480. It can therefore compare `dbg_vec_o` against the exact addresses the select bit must give. Directed cycles put a set and a clear on the same edge, for both the pending flag and the break request, to reach the priority corners. They also write all ones to the reserved positions. Random cycles then mix writes, pulses and status values so that flag toggles and done pulses occur back to back.

// File: rtl/dbg_ctl_pkg.sv
package dbg_ctl_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned STAT_W  = 10;
  // bit positions decoded by the probe software
  localparam int unsigned PEND_B  = 18;
  localparam int unsigned SVC_B   = 15;
  localparam int unsigned VSEL_B  = 14;
  localparam int unsigned BRK_B   = 12;
  // positions that always read zero
  localparam logic [REG_W-1:0] ZERO_MASK = 32'h1F02_2FF7;
endpackage

// File: rtl/dbg_pend_unit.sv
module dbg_pend_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic wr_clr_i,
  input  logic fast_i,
  output logic pend_o,
  output logic done_o
);
  logic pend_q, pend_d;
  logic done_q, done_d;

  always_comb begin
    pend_d = pend_q;
    if (req_i)                 pend_d = 1'b1;
    else if (wr_clr_i || fast_i) pend_d = 1'b0;
    done_d = pend_q & ~pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      done_q <= done_d;
    end
  end

  assign pend_o = pend_q;
  assign done_o = done_q;

  // R5
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> pend_q);
  // R3
  pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_i && (wr_clr_i || fast_i)) |=> !pend_q);
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!pend_q && $past(pend_q)));
endmodule

// File: rtl/dbg_ctl_bits.sv
module dbg_ctl_bits (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic svc_bit_i,
  input  logic vsel_bit_i,
  input  logic brk_bit_i,
  input  logic ack_i,
  output logic svc_o,
  output logic vsel_o,
  output logic brk_o
);
  logic svc_q, vsel_q, brk_q;
  logic svc_d, vsel_d, brk_d;
  logic rw_en;

  assign rw_en = wr_i;

  always_comb begin
    svc_d  = rw_en ? svc_bit_i  : svc_q;
    vsel_d = rw_en ? vsel_bit_i : vsel_q;
    brk_d  = brk_q;
    if (wr_i && brk_bit_i) brk_d = 1'b1;
    else if (ack_i)        brk_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svc_q  <= 1'b0;
      vsel_q <= 1'b0;
      brk_q  <= 1'b0;
    end else begin
      svc_q  <= svc_d;
      vsel_q <= vsel_d;
      brk_q  <= brk_d;
    end
  end

  assign svc_o  = svc_q;
  assign vsel_o = vsel_q;
  assign brk_o  = brk_q;

  // R8
  brk_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && brk_bit_i) |=> brk_q);
  // R9
  brk_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !(wr_i && brk_bit_i)) |=> !brk_q);
  // R6
  svc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(svc_q));
endmodule

// File: rtl/dbg_rd_mux.sv
module dbg_rd_mux
  import dbg_ctl_pkg::*;
#(
  parameter logic [REG_W-1:0] VEC_SET = 32'hFF20_0200,
  parameter logic [REG_W-1:0] VEC_CLR = 32'hBFC0_0480
) (
  input  logic              pend_i,
  input  logic              svc_i,
  input  logic              vsel_i,
  input  logic              brk_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic [REG_W-1:0]  rd_o,
  output logic [REG_W-1:0]  vec_o
);
  always_comb begin
    rd_o          = '0;
    rd_o[31:29]   = stat_i[2:0];
    rd_o[23:19]   = stat_i[7:3];
    rd_o[16]      = stat_i[8];
    rd_o[3]       = stat_i[9];
    rd_o[PEND_B]  = pend_i;
    rd_o[SVC_B]   = svc_i;
    rd_o[VSEL_B]  = vsel_i;
    rd_o[BRK_B]   = brk_i;
  end

  assign vec_o = vsel_i ? VEC_SET : VEC_CLR;
endmodule

// File: rtl/dbg_probe_ctl.sv
module dbg_probe_ctl
  import dbg_ctl_pkg::*;
#(
  parameter logic [31:0] VEC_SET = 32'hFF20_0200,
  parameter logic [31:0] VEC_CLR = 32'hBFC0_0480
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] rd_data_o,
  input  logic        acc_req_i,
  input  logic        fast_done_i,
  input  logic        brk_ack_i,
  input  logic [9:0]  ext_stat_i,
  output logic        pend_o,
  output logic        svc_en_o,
  output logic        brk_req_o,
  output logic [31:0] dbg_vec_o,
  output logic        acc_done_o
);
  logic vsel;
  logic wr_clr;

  assign wr_clr = wr_en_i & ~wr_data_i[PEND_B];

  dbg_pend_unit u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (acc_req_i),
    .wr_clr_i (wr_clr),
    .fast_i   (fast_done_i),
    .pend_o   (pend_o),
    .done_o   (acc_done_o)
  );

  dbg_ctl_bits u_bits (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (wr_en_i),
    .svc_bit_i  (wr_data_i[SVC_B]),
    .vsel_bit_i (wr_data_i[VSEL_B]),
    .brk_bit_i  (wr_data_i[BRK_B]),
    .ack_i      (brk_ack_i),
    .svc_o      (svc_en_o),
    .vsel_o     (vsel),
    .brk_o      (brk_req_o)
  );

  dbg_rd_mux #(.VEC_SET(VEC_SET), .VEC_CLR(VEC_CLR)) u_rd (
    .pend_i (pend_o),
    .svc_i  (svc_en_o),
    .vsel_i (vsel),
    .brk_i  (brk_req_o),
    .stat_i (ext_stat_i),
    .rd_o   (rd_data_o),
    .vec_o  (dbg_vec_o)
  );

  // R2
  zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o & ZERO_MASK) == '0);
  // R7
  vec_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_vec_o == VEC_SET) || (dbg_vec_o == VEC_CLR));
  // R7
  vec_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[VSEL_B] == (dbg_vec_o == VEC_SET));
endmodule

// File: tb/dbg_probe_ctl_tb_top.sv
module dbg_probe_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        acc_req, fast_done, brk_ack;
  logic [9:0]  stat;
  logic        pend, svc, brk, done;
  logic [31:0] vec;

  int n_run = 0;
  int n_fail = 0;

  // reference state
  int m_pend, m_svc, m_vsel, m_brk, m_done;

  always #2 clk = ~clk;

  dbg_probe_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .acc_req_i(acc_req), .fast_done_i(fast_done),
    .brk_ack_i(brk_ack), .ext_stat_i(stat), .pend_o(pend),
    .svc_en_o(svc), .brk_req_o(brk), .dbg_vec_o(vec), .acc_done_o(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd();
    logic [31:0] r = '0;
    r[31:29] = stat[2:0];
    r[23:19] = stat[7:3];
    r[16]    = stat[8];
    r[3]     = stat[9];
    r[18] = m_pend[0];
    r[15] = m_svc[0];
    r[14] = m_vsel[0];
    r[12] = m_brk[0];
    return r;
  endfunction

  task automatic compare_all();
    chk("R3/R4/R5 pend", {31'd0, pend}, m_pend);
    chk("R6 svc_en", {31'd0, svc}, m_svc);
    chk("R8/R9 brk_req", {31'd0, brk}, m_brk);
    chk("R7 vector", vec, m_vsel ? 32'hFF20_0200 : 32'hBFC0_0480);
    chk("R12 acc_done", {31'd0, done}, m_done);
    chk("R2/R10/R11 rd_data", rd_data, exp_rd());
  endtask

  // one cycle: drive at negedge, check, advance model across the edge
  task automatic step(input logic w, input logic [31:0] d, input logic rq,
                      input logic fd, input logic ak, input logic [9:0] st);
    int np, nb;
    @(negedge clk);
    wr_en = w; wr_data = d; acc_req = rq; fast_done = fd; brk_ack = ak; stat = st;
    #1;
    compare_all();
    np = rq ? 1 : ((w && !d[18]) || fd) ? 0 : m_pend;
    nb = (w && d[12]) ? 1 : ak ? 0 : m_brk;
    m_done = (m_pend == 1 && np == 0) ? 1 : 0;
    m_pend = np;
    m_brk = nb;
    if (w) begin m_svc = d[15]; m_vsel = d[14]; end
    @(posedge clk);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 0; wr_data = 0; acc_req = 0; fast_done = 0;
    brk_ack = 0; stat = 0;
    m_pend = 0; m_svc = 0; m_vsel = 0; m_brk = 0; m_done = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    // R1 reset state
    chk("R1 reset pend", {31'd0, pend}, 0);
    chk("R1 reset brk", {31'd0, brk}, 0);
    chk("R1 reset rd", rd_data, 0);
    rst_n = 1'b1;
    // R2 reserved bits written with ones
    step(1, 32'h1F02_2FF7, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    // R10 status reflection, R11 immediate
    step(0, 0, 0, 0, 0, 10'h3FF);
    step(0, 0, 0, 0, 0, 10'h155);
    // R5 request, R3 write-1 keeps, R3 write-0 clears, R12 done
    step(0, 0, 1, 0, 0, 0);
    step(1, 32'h0004_0000, 0, 0, 0, 0);
    step(1, 32'h0000_0000, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    // R4 fast-data clear
    step(0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    // R5 priority over both clears
    step(0, 0, 1, 0, 0, 0);
    step(1, 32'h0, 1, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    // R6 R7 plain bits
    step(1, 32'h0004_C000, 0, 0, 0, 0);
    step(1, 32'h0004_4000, 0, 0, 0, 0);
    step(1, 32'h0004_0000, 0, 0, 0, 0);
    // R8 set, write-0 ignored, R9 ack clear and set-wins
    step(1, 32'h0004_1000, 0, 0, 0, 0);
    step(1, 32'h0004_0000, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0);
    step(1, 32'h0004_1000, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] rd;
      rd = $urandom;
      step(($urandom % 3) == 0, rd, ($urandom % 4) == 0, ($urandom % 5) == 0,
           ($urandom % 4) == 0, 10'($urandom));
    end
    step(0, 0, 0, 0, 0, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule